// File: doc/BRIEF.md
# Multiplier Chain Self-Test Controller

This block runs a built-in self-test on a cascade of signed multiplier stages, the kind of structure used to catch transient upsets in programmable logic. A host sends single-byte commands over a ready/valid link. After a start command, a 32-bit LFSR produces a fresh operand pair every cycle. The pair enters the multiplier cascade. In parallel, a separate reference path delays the same operands by the cascade latency and recomputes the result on its own. Once the pipeline has filled, the controller compares the two results every cycle and counts each disagreement.

At fixed intervals the accumulated count goes back to the host as a two-byte frame. A single-pass start stops after the first report. A looping start keeps running until the host sends an end command. An upset-injection input XORs a mask into the cascade output only. This lets the count be steered from outside without touching the reference.

Top module: `mbist_ctrl`

## Requirements
- R1: While reset is held and straight after it, `rpt_valid` is 0, `host_ready` is 1 and no test is running.
- R2: Command bytes: 0x01 starts a single pass and 0x02 starts a looping run, both only when idle. 0x03 ends a run. Every other byte, and any start byte while running, is ignored. A start reseeds the LFSR and clears the count and interval timer.
- R3: The cascade has STAGES registered stages (default 4). Each stage keeps the low MUL_W (18) bits of the signed product of its data input and the multiplicand. Stage 0 takes data = LFSR[17:0] and multiplicand = LFSR[31:14]. The multiplicand travels with the data. With no injected upset, the cascade always matches the reference and every report reads 0.
- R4: The first STAGES cycles of a run are not compared, so an upset injected in run cycles 0 to STAGES-1 is never counted.
- R5: Each compared cycle in which the cascade output XOR `upset_inj` differs from the reference adds exactly one to the count.
- R6: Run cycle INTERVAL-1 of each interval is its report cycle. The count is then sent as two bytes, high byte first, and cleared.
- R7: A mismatch in the report cycle is part of that report. A mismatch in the next cycle belongs to the next report.
- R8: In a single pass the controller goes idle after its one report and sends nothing more.
- R9: A looping run reports every interval. After the end command it goes idle at once and sends nothing more.
- R10: The count saturates at 0xFFFF.
- R11: While `rpt_valid` is 1 and `rpt_ready` is 0, `rpt_byte` and `rpt_valid` hold.
- R12: If the previous frame is still being sent at a report cycle, that report is skipped. The count is not cleared and carries into the next report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_valid | input | 1 | Command byte valid |
| host_byte | input | 8 | Command byte |
| host_ready | output | 1 | Command byte accepted (always 1) |
| rpt_valid | output | 1 | Report byte valid |
| rpt_byte | output | 8 | Report byte, high byte of the count first |
| rpt_ready | input | 1 | Host takes the report byte |
| upset_inj | input | MUL_W | Mask XORed into the cascade output before the compare |

## Verification
Two events can fall in the same cycle: a mismatch being counted and the report snapshot that clears the counter. The bench injects an upset exactly on run cycle INTERVAL-1 and checks that the frame includes it. It also injects on the first cycle of the next interval and checks that this one lands in the following frame. A second same-cycle case is a report boundary while the sender is still stalled. The bench holds `rpt_ready` low across a boundary. It expects that interval's count to merge into the next frame rather than be lost.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
    typedef enum logic {ST_IDLE, ST_RUN} run_st_e;
    typedef enum logic {MODE_ONE, MODE_LOOP} run_mode_e;

    localparam logic [7:0] CMD_ONE  = 8'h01;
    localparam logic [7:0] CMD_LOOP = 8'h02;
    localparam logic [7:0] CMD_STOP = 8'h03;
    localparam int         CNT_W    = 16;
endpackage

// File: rtl/mbist_lfsr.sv
module mbist_lfsr #(
    parameter logic [31:0] SEED = 32'h1D0C_5A73,
    parameter logic [31:0] POLY = 32'h8020_0003
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_i,
    output logic [31:0] state_o
);
    logic [31:0] st_d, st_q;

    always_comb begin
        if (load_i) st_d = SEED;
        else        st_d = {st_q[30:0], 1'b0} ^ (st_q[31] ? POLY : 32'h0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEED;
        else        st_q <= st_d;
    end

    assign state_o = st_q;
endmodule

// File: rtl/mbist_chain.sv
module mbist_chain #(
    parameter int STAGES = 4,
    parameter int MUL_W  = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MUL_W-1:0] a_i,
    input  logic [MUL_W-1:0] b_i,
    output logic [MUL_W-1:0] y_o
);
    localparam int PROD_W = 2 * MUL_W;

    logic [MUL_W-1:0] pa [0:STAGES];
    logic [MUL_W-1:0] pb [0:STAGES-1];

    assign pa[0] = a_i;
    assign pb[0] = b_i;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        logic signed [PROD_W-1:0] prod;
        logic [MUL_W-1:0] a_d, a_q;

        always_comb begin
            prod = $signed(pa[k]) * $signed(pb[k]);
            a_d  = prod[MUL_W-1:0];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) a_q <= '0;
            else        a_q <= a_d;
        end
        assign pa[k+1] = a_q;

        if (k < STAGES - 1) begin : g_pass
            logic [MUL_W-1:0] b_d, b_q;
            always_comb b_d = pb[k];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) b_q <= '0;
                else        b_q <= b_d;
            end
            assign pb[k+1] = b_q;
        end
    end

    assign y_o = pa[STAGES];
endmodule

// File: rtl/mbist_ref.sv
module mbist_ref #(
    parameter int STAGES = 4,
    parameter int MUL_W  = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MUL_W-1:0] a_i,
    input  logic [MUL_W-1:0] b_i,
    output logic [MUL_W-1:0] y_o
);
    localparam int PROD_W = 2 * MUL_W;

    typedef struct packed {
        logic [STAGES-1:0][MUL_W-1:0] a;
        logic [STAGES-1:0][MUL_W-1:0] b;
    } dly_t;

    dly_t dl_d, dl_q;

    always_comb begin
        dl_d.a[0] = a_i;
        dl_d.b[0] = b_i;
        for (int k = 1; k < STAGES; k++) begin
            dl_d.a[k] = dl_q.a[k-1];
            dl_d.b[k] = dl_q.b[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dl_q <= '0;
        else        dl_q <= dl_d;
    end

    always_comb begin
        logic signed [PROD_W-1:0] p;
        logic [MUL_W-1:0] x;
        x = dl_q.a[STAGES-1];
        for (int k = 0; k < STAGES; k++) begin
            p = $signed(x) * $signed(dl_q.b[STAGES-1]);
            x = p[MUL_W-1:0];
        end
        y_o = x;
    end
endmodule

// File: rtl/mbist_tx.sv
module mbist_tx #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] word_i,
    output logic             busy_o,
    output logic             tx_valid_o,
    output logic [7:0]       tx_data_o,
    input  logic             tx_ready_i
);
    typedef struct packed {
        logic       valid;
        logic       second;
        logic [7:0] cur;
        logic [7:0] lo;
    } tx_t;

    tx_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.valid) begin
            if (load_i) begin
                s_d.valid  = 1'b1;
                s_d.second = 1'b0;
                s_d.cur    = word_i[15:8];
                s_d.lo     = word_i[7:0];
            end
        end else if (tx_ready_i) begin
            if (!s_q.second) begin
                s_d.second = 1'b1;
                s_d.cur    = s_q.lo;
            end else begin
                s_d.valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o     = s_q.valid;
    assign tx_valid_o = s_q.valid;
    assign tx_data_o  = s_q.cur;

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o))); // R11
    AST_TX_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && tx_ready_i && !s_q.second) |=> tx_valid_o); // R6
endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
    import mbist_pkg::*;
#(
    parameter int          STAGES   = 4,
    parameter int          MUL_W    = 18,
    parameter int          INTERVAL = 4096,
    parameter logic [31:0] SEED     = 32'h1D0C_5A73
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_valid,
    input  logic [7:0]       host_byte,
    output logic             host_ready,
    output logic             rpt_valid,
    output logic [7:0]       rpt_byte,
    input  logic             rpt_ready,
    input  logic [MUL_W-1:0] upset_inj
);
    localparam int FILL_W = $clog2(STAGES + 1);
    localparam int IVL_W  = $clog2(INTERVAL);
    localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(STAGES);
    localparam logic [IVL_W-1:0]  IVL_LAST  = IVL_W'(INTERVAL - 1);
    localparam logic [CNT_W-1:0]  CNT_MAX   = '1;

    typedef struct packed {
        run_st_e           st;
        run_mode_e         mode;
        logic [FILL_W-1:0] fill;
        logic [IVL_W-1:0]  ivl;
        logic [CNT_W-1:0]  err;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [31:0]      lfsr;
    logic             lfsr_load;
    logic [MUL_W-1:0] chain_y, ref_y;
    logic             tx_busy;
    logic             cmp_en, miss, last_slot, report_fire;
    logic [CNT_W-1:0] err_inc;
    logic             cmd_start, cmd_stop;

    mbist_lfsr #(.SEED(SEED)) i_lfsr (
        .clk(clk), .rst_n(rst_n), .load_i(lfsr_load), .state_o(lfsr)
    );

    mbist_chain #(.STAGES(STAGES), .MUL_W(MUL_W)) i_chain (
        .clk(clk), .rst_n(rst_n),
        .a_i(lfsr[MUL_W-1:0]), .b_i(lfsr[31:32-MUL_W]), .y_o(chain_y)
    );

    mbist_ref #(.STAGES(STAGES), .MUL_W(MUL_W)) i_ref (
        .clk(clk), .rst_n(rst_n),
        .a_i(lfsr[MUL_W-1:0]), .b_i(lfsr[31:32-MUL_W]), .y_o(ref_y)
    );

    mbist_tx #(.CNT_W(CNT_W)) i_tx (
        .clk(clk), .rst_n(rst_n),
        .load_i(report_fire), .word_i(err_inc), .busy_o(tx_busy),
        .tx_valid_o(rpt_valid), .tx_data_o(rpt_byte), .tx_ready_i(rpt_ready)
    );

    assign host_ready = 1'b1;

    always_comb begin
        c_d         = c_q;
        lfsr_load   = 1'b0;
        cmd_start   = host_valid && c_q.st == ST_IDLE &&
                      (host_byte == CMD_ONE || host_byte == CMD_LOOP);
        cmd_stop    = host_valid && c_q.st == ST_RUN && host_byte == CMD_STOP;
        cmp_en      = c_q.st == ST_RUN && c_q.fill == FILL_FULL;
        miss        = cmp_en && ((chain_y ^ upset_inj) != ref_y);
        err_inc     = (miss && c_q.err != CNT_MAX) ? c_q.err + 1'b1 : c_q.err;
        last_slot   = c_q.st == ST_RUN && c_q.ivl == IVL_LAST;
        report_fire = last_slot && !tx_busy;

        if (c_q.st == ST_IDLE) begin
            if (cmd_start) begin
                c_d.st    = ST_RUN;
                c_d.mode  = (host_byte == CMD_LOOP) ? MODE_LOOP : MODE_ONE;
                c_d.fill  = '0;
                c_d.ivl   = '0;
                c_d.err   = '0;
                lfsr_load = 1'b1;
            end
        end else begin
            if (c_q.fill != FILL_FULL) c_d.fill = c_q.fill + 1'b1;
            c_d.ivl = last_slot ? '0 : c_q.ivl + 1'b1;
            c_d.err = report_fire ? '0 : err_inc;
            if ((report_fire && c_q.mode == MODE_ONE) || cmd_stop) c_d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, mode: MODE_ONE, fill: '0, ivl: '0, err: '0};
        else        c_q <= c_d;
    end

    AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> (c_q.st == ST_RUN && c_q.err == '0 && c_q.ivl == '0)); // R2
    AST_NO_EARLY_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_IDLE) |=> !cmp_en); // R4
    AST_CLEAR_AFTER_RPT: assert property (@(posedge clk) disable iff (!rst_n)
        report_fire |=> (c_q.err == '0 && rpt_valid)); // R6
    AST_ONE_SHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (report_fire && c_q.mode == MODE_ONE) |=> c_q.st == ST_IDLE); // R8
    AST_END_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |=> c_q.st == ST_IDLE); // R9
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.err == CNT_MAX && !report_fire && c_q.st == ST_RUN) |=> c_q.err == CNT_MAX); // R10
    AST_DEFER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (last_slot && tx_busy && c_q.st == ST_RUN) |=> c_q.err >= $past(c_q.err)); // R12
endmodule

// File: tb/test_mbist_ctrl.sv
module test_mbist_ctrl;
    localparam int STAGES = 4;
    localparam int MUL_W  = 18;
    localparam int IVL    = 32;
    localparam int SAT_IVL = 70000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic             host_valid = 1'b0;
    logic [7:0]       host_byte  = 8'h00;
    logic             host_ready;
    logic             rpt_valid;
    logic [7:0]       rpt_byte;
    logic             rpt_ready  = 1'b1;
    logic [MUL_W-1:0] upset_inj  = '0;

    logic             s_valid = 1'b0;
    logic [7:0]       s_byte  = 8'h00;
    logic             s_ready;
    logic             s_rpt_valid;
    logic [7:0]       s_rpt_byte;
    logic [MUL_W-1:0] s_inj   = '0;

    mbist_ctrl #(.STAGES(STAGES), .MUL_W(MUL_W), .INTERVAL(IVL)) i_mbist_ctrl (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_byte(host_byte),
        .host_ready(host_ready), .rpt_valid(rpt_valid), .rpt_byte(rpt_byte),
        .rpt_ready(rpt_ready), .upset_inj(upset_inj)
    );

    mbist_ctrl #(.STAGES(STAGES), .MUL_W(MUL_W), .INTERVAL(SAT_IVL)) i_mbist_ctrl_sat (
        .clk(clk), .rst_n(rst_n), .host_valid(s_valid), .host_byte(s_byte),
        .host_ready(s_ready), .rpt_valid(s_rpt_valid), .rpt_byte(s_rpt_byte),
        .rpt_ready(1'b1), .upset_inj(s_inj)
    );

    typedef struct { int val; string req; } exp_t;
    exp_t exp_q[$];

    int n_chk = 0;
    int n_bad = 0;
    int frames = 0;
    bit done = 1'b0;

    bit       hit  [0:511];
    bit [7:0] cmdb [0:511];
    int stall_until = 0;
    int probe_t = -1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic push(input int v, input string r);
        exp_t e;
        e.val = v;
        e.req = r;
        exp_q.push_back(e);
    endtask

    task automatic clear_plan();
        for (int i = 0; i < 512; i++) begin
            hit[i]  = 1'b0;
            cmdb[i] = 8'h00;
        end
        stall_until = 0;
        probe_t = -1;
    endtask

    task automatic send_cmd(input logic [7:0] b);
        @(negedge clk);
        host_valid = 1'b1;
        host_byte  = b;
        @(negedge clk);
        host_valid = 1'b0;
    endtask

    task automatic run_seq(input int n);
        for (int t = 0; t < n; t++) begin
            upset_inj  = hit[t] ? '1 : '0;
            host_valid = (cmdb[t] != 8'h00);
            host_byte  = cmdb[t];
            rpt_ready  = (t >= stall_until);
            if (t == probe_t)
                chk(rpt_valid && rpt_byte == 8'h00, "R11 held byte during stall",
                    {rpt_valid, rpt_byte}, 9'h100);
            @(negedge clk);
        end
        upset_inj  = '0;
        host_valid = 1'b0;
        rpt_ready  = 1'b1;
    endtask

    // expected count of one interval from the injection plan
    function automatic int count_in(input int lo, input int hi);
        int c = 0;
        for (int t = lo; t <= hi; t++) if (hit[t] && t >= STAGES) c++;
        return c;
    endfunction

    // monitor: assembles frames and checks them against the scoreboard
    initial begin
        logic [7:0] hi_b;
        bit have_hi;
        int frame;
        exp_t e;
        have_hi = 1'b0;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && rpt_valid && rpt_ready) begin
                if (!have_hi) begin
                    hi_b = rpt_byte;
                    have_hi = 1'b1;
                end else begin
                    frame = {16'h0, hi_b, rpt_byte};
                    have_hi = 1'b0;
                    frames++;
                    if (exp_q.size() == 0) chk(1'b0, "R6 unexpected frame", frame, -1);
                    else begin
                        e = exp_q.pop_front();
                        chk(frame == e.val, e.req, frame, e.val);
                    end
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int f0;
        logic [15:0] sat_frame;
        bit got_hi;
        clear_plan();
        repeat (3) @(negedge clk);
        chk(!rpt_valid && host_ready, "R1 reset outputs", {rpt_valid, host_ready}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rpt_valid && host_ready, "R1 after reset", {rpt_valid, host_ready}, 1);

        // R2: unknown and stop bytes while idle do nothing
        f0 = frames;
        send_cmd(8'h55);
        send_cmd(8'h03);
        repeat (3 * IVL) @(negedge clk);
        chk(frames == f0 && !rpt_valid, "R2 ignored bytes", frames - f0, 0);

        // R3/R8: single pass, clean chain
        clear_plan();
        push(0, "R3 clean chain matches reference");
        f0 = frames;
        send_cmd(8'h01);
        run_seq(IVL + 8);
        repeat (3 * IVL) @(negedge clk);
        chk(frames == f0 + 1, "R8 single pass sends one frame", frames - f0, 1);

        // R4/R5/R7: single pass with upsets, one during fill, one on the report cycle
        clear_plan();
        hit[1] = 1; hit[3] = 1; hit[10] = 1; hit[11] = 1; hit[12] = 1;
        hit[IVL-1] = 1; hit[IVL+1] = 1;
        push(count_in(0, IVL - 1), "R4 R5 R7 single pass count");
        f0 = frames;
        send_cmd(8'h01);
        run_seq(IVL + 8);
        repeat (2 * IVL) @(negedge clk);
        chk(frames == f0 + 1, "R8 no frame after single pass", frames - f0, 1);

        // R9/R6/R7: looping run, ignored byte mid-run, then end
        clear_plan();
        hit[5] = 1; hit[IVL-1] = 1; hit[IVL] = 1; hit[40] = 1; hit[41] = 1;
        hit[70] = 1; hit[71] = 1; hit[72] = 1; hit[90] = 1; hit[3*IVL-1] = 1;
        cmdb[50] = 8'h55;
        cmdb[100] = 8'h03;
        push(count_in(0, IVL - 1), "R7 loop interval 1");
        push(count_in(IVL, 2 * IVL - 1), "R7 loop interval 2");
        push(count_in(2 * IVL, 3 * IVL - 1), "R9 loop interval 3");
        f0 = frames;
        send_cmd(8'h02);
        run_seq(101);
        repeat (3 * IVL) @(negedge clk);
        chk(frames == f0 + 3, "R9 end stops reports", frames - f0, 3);

        // R11/R12: stalled host across a report boundary
        clear_plan();
        hit[10] = 1; hit[40] = 1; hit[50] = 1; hit[80] = 1;
        stall_until = 70;
        probe_t = 69;
        cmdb[100] = 8'h03;
        push(1, "R12 first frame after stall");
        push(3, "R12 skipped report carried over");
        f0 = frames;
        send_cmd(8'h02);
        run_seq(101);
        repeat (3 * IVL) @(negedge clk);
        chk(frames == f0 + 2, "R12 frame count", frames - f0, 2);
        chk(exp_q.size() == 0, "R6 all expected frames seen", exp_q.size(), 0);

        // R10: saturation on the long-interval instance
        @(negedge clk);
        s_valid = 1'b1;
        s_byte  = 8'h01;
        @(negedge clk);
        s_valid = 1'b0;
        s_inj   = '1;
        got_hi  = 1'b0;
        sat_frame = '0;
        for (int i = 0; i < SAT_IVL + 50; i++) begin
            @(negedge clk);
            #1;
            if (s_rpt_valid) begin
                if (!got_hi) begin
                    sat_frame[15:8] = s_rpt_byte;
                    got_hi = 1'b1;
                end else begin
                    sat_frame[7:0] = s_rpt_byte;
                    break;
                end
            end
        end
        s_inj = '0;
        chk(sat_frame == 16'hFFFF, "R10 saturated count", sat_frame, 16'hFFFF);

        finish_run();
    end
endmodule